// File: doc/BRIEF.md
# Bus Sizing Lane Steering Unit

This unit takes one internal load or store request at a time and turns it into one or more beats on a 32-bit big-endian external data bus. It first checks that the request is naturally aligned for its size, and rejects it if not. It then works out how many beats the target port width needs. It places the addressed operand bytes on the byte lanes that the port actually wires up. On reads, it gathers the returned bytes back into their operand positions.

Operands travel inside the block in place. The byte at address offset `o` within the aligned word sits in operand byte `o`. Operand byte 0 is the most significant byte, bits 31:24. A narrow port is always wired to the most significant lanes, so data for it is shifted up onto those lanes. A word moved through a narrow port is split into successive beats, and the beat address advances by the port width each time. The block always starts from the full 32-bit port view and sizes down only when told the target is a narrow port behind the internal memory controller.

Top module: `busLaneSteer`

## Requirements
- R1: Alignment rules by size:
  - a byte request is legal at any address;
  - a half-word request is legal only when `reqAddr[0]` is 0;
  - a word or burst request is legal only when `reqAddr[1:0]` is 0.
  
  An illegal request raises `alignErr` for exactly one cycle, in the cycle after acceptance. It starts no beat and produces no `rspDone`.
- R2: Size and port encodings:
  - `reqSize`: 0 is a byte, 1 is a half-word, 2 is a word, and 3 is a burst, which is treated as one word operand.
  - `portSel`: 0 selects a 32-bit port, 1 selects 16 bits, 2 selects 8 bits, and 3 selects 32 bits.
  - When `reqInternal` is 0, the port is 32 bits whatever `portSel` holds.
- R3: A legal request produces max(1, sizeBytes/portBytes) beats. Beat k carries address `reqAddr + k*portBytes`.
- R4: Byte lane l is `busWdata/busRdata[31-8l -: 8]` and its enable is `busBe[3-l]`. In a beat at address B, exactly the lanes from (B mod portBytes) up to (B mod portBytes) + min(sizeBytes, portBytes) - 1 are enabled, and only lanes below portBytes are ever enabled. Disabled write lanes drive 0.
- R5: On a write, operand byte o (`reqWdata[31-8o -: 8]`) is driven on lane (o mod portBytes) in the beat whose address covers offset o.
- R6: On a read, operand byte o of `rspRdata` is taken from lane (o mod portBytes) of the beat covering offset o. Operand bytes outside the request read as 0. `rspRdata` is valid when `rspDone` is high.
- R7: `rspDone` is a one-cycle pulse in the cycle after the final acknowledged beat.
- R8: While `busValid` is high and `busAck` is low, `busAddr`, `busBe` and `busWdata` hold their values. `reqReady` is 0 while a transfer is active, and requests offered then are not accepted.
- R9: After reset, `busValid`, `alignErr` and `rspDone` are 0 and `reqReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Unit idle, request accepted this cycle if valid |
| reqAddr | input | ADDR_W | Byte address of the operand |
| reqSize | input | 2 | 0 byte, 1 half-word, 2 word, 3 burst |
| reqWrite | input | 1 | 1 for store, 0 for load |
| reqWdata | input | 32 | Store operand, bytes in place |
| portSel | input | 2 | Target port width: 0 32-bit, 1 16-bit, 2 8-bit, 3 32-bit |
| reqInternal | input | 1 | Transfer handled by the internal memory controller; 0 forces 32-bit |
| busValid | output | 1 | Beat presented on the bus |
| busAck | input | 1 | Beat completed this cycle |
| busAddr | output | ADDR_W | Beat address |
| busWrite | output | 1 | Beat direction |
| busBe | output | 4 | Lane enables, bit 3 is lane 0 (bits 31:24) |
| busWdata | output | 32 | Write data on lanes |
| busRdata | input | 32 | Read data from lanes |
| alignErr | output | 1 | One-cycle misalignment flag |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Gathered load operand, bytes in place |

## Verification
The bench sweeps these inputs against each other:
- all four low address offsets;
- all four size codes;
- all three port widths, with the internal flag both set and clear;
- both directions.

Every misaligned combination is expected to be rejected. The legal ones tell a shift error apart from a beat-count error, because each narrow-port case has its own beat address and lane enables. A responder memory whose byte values depend on address shows whether read bytes landed in the right operand position. Write-back into that memory shows whether store bytes were steered to the right lanes and left their neighbours untouched. Every second transfer inserts a wait state, to test that beats hold steady.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int LANES = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_BURST = 2'd3
  } sizeCode_e;

  typedef struct packed {
    logic load;
    logic advance;
    logic capture;
  } laneStrobe_t;

  // log2 of the operand size in bytes
  function automatic logic [1:0] sizeLog(input logic [1:0] size);
    return (size == SZ_BURST) ? 2'd2 : size;
  endfunction

  // log2 of the port width in bytes
  function automatic logic [1:0] portLog(input logic [1:0] sel, input logic internal);
    if (!internal) return 2'd2;
    case (sel)
      2'd1:    return 2'd1;
      2'd2:    return 2'd0;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/laneCtrl.sv
module laneCtrl
  import lane_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        misaligned,
  input  logic        busAck,
  input  logic        lastBeat,
  input  logic        writeReg,
  output laneStrobe_t strobe,
  output logic        busValid,
  output logic        reqReady,
  output logic        alignErr,
  output logic        rspDone
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_e;
  state_e state;

  logic accept;
  logic beatDone;

  assign accept   = reqValid && (state == ST_IDLE);
  assign beatDone = (state == ST_BUSY) && busAck;

  assign strobe.load    = accept && !misaligned;
  assign strobe.advance = beatDone && !lastBeat;
  assign strobe.capture = beatDone && !writeReg;

  assign busValid = (state == ST_BUSY);
  assign reqReady = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      alignErr <= 1'b0;
      rspDone  <= 1'b0;
    end else begin
      alignErr <= accept && misaligned;
      rspDone  <= beatDone && lastBeat;
      case (state)
        ST_IDLE: if (accept && !misaligned) state <= ST_BUSY;
        ST_BUSY: if (beatDone && lastBeat) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  align_no_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> !busValid && !rspDone);

  // R1
  align_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |=> !alignErr);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspDone) |-> $past(busValid && busAck && lastBeat));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R8
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busAck |=> busValid);

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> !reqReady);
endmodule

// File: rtl/laneDatapath.sv
module laneDatapath
  import lane_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        portSel,
  input  logic              reqInternal,
  input  logic [DATA_W-1:0] busRdata,
  output logic              misaligned,
  output logic              lastBeat,
  output logic              writeReg,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [LANES-1:0]  busBe,
  output logic [DATA_W-1:0] rspRdata
);
  logic [ADDR_W-1:0] addrReg;
  logic [1:0]        szLogR;
  logic [1:0]        pbLogR;
  logic              writeR;
  logic [DATA_W-1:0] wdataR;
  logic [DATA_W-1:0] rdAcc;
  logic [1:0]        beatIdx;

  logic [1:0] reqSzLog;
  assign reqSzLog = sizeLog(reqSize);

  assign misaligned = ((reqSzLog == 2'd1) && reqAddr[0]) ||
                      ((reqSzLog == 2'd2) && (reqAddr[1:0] != 2'd0));

  // bytes per beat and number of beats
  logic [1:0] nbLog;
  logic [1:0] beatsLog;
  logic [2:0] beatsCnt;
  assign nbLog    = (szLogR < pbLogR) ? szLogR : pbLogR;
  assign beatsLog = szLogR - nbLog;
  assign beatsCnt = 3'd1 << beatsLog;
  assign lastBeat = ({1'b0, beatIdx} == (beatsCnt - 3'd1));

  // beat address and lane window
  logic [ADDR_W-1:0] beatStep;
  logic [ADDR_W-1:0] beatAddr;
  logic [2:0]        pbBytes;
  logic [1:0]        pbMask;
  logic [1:0]        laneStart;
  logic [1:0]        laneBase;
  logic [2:0]        laneEnd;
  assign beatStep  = ADDR_W'(beatIdx) << pbLogR;
  assign beatAddr  = addrReg + beatStep;
  assign pbBytes   = 3'd1 << pbLogR;
  assign pbMask    = 2'(pbBytes - 3'd1);
  assign laneStart = beatAddr[1:0] & pbMask;
  assign laneBase  = beatAddr[1:0] & ~pbMask;
  assign laneEnd   = {1'b0, laneStart} + (3'd1 << nbLog);

  logic [LANES-1:0]  laneOn;
  logic [LANES-1:0]  takeByte;
  logic [DATA_W-1:0] gathered;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [1:0] srcIdx;
    logic [1:0] fromLane;
    assign srcIdx    = laneBase + 2'(l);
    assign laneOn[l] = (3'(l) >= {1'b0, laneStart}) && (3'(l) < laneEnd);
    assign busWdata[8*(LANES-1-l) +: 8] =
      laneOn[l] ? wdataR[8*(2'd3 - srcIdx) +: 8] : 8'h00;
    assign busBe[LANES-1-l] = laneOn[l];
    // operand byte l comes back on lane (l - base)
    assign fromLane    = 2'(l) - laneBase;
    assign takeByte[l] = (2'(l) >= laneBase) && laneOn[fromLane];
    assign gathered[8*(LANES-1-l) +: 8] = busRdata[8*(2'd3 - fromLane) +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      szLogR  <= 2'd0;
      pbLogR  <= 2'd2;
      writeR  <= 1'b0;
      wdataR  <= '0;
      rdAcc   <= '0;
      beatIdx <= 2'd0;
    end else begin
      if (strobe.load) begin
        addrReg <= reqAddr;
        szLogR  <= reqSzLog;
        pbLogR  <= portLog(portSel, reqInternal);
        writeR  <= reqWrite;
        wdataR  <= reqWdata;
        rdAcc   <= '0;
        beatIdx <= 2'd0;
      end else begin
        if (strobe.advance) beatIdx <= beatIdx + 2'd1;
        if (strobe.capture) begin
          for (int j = 0; j < LANES; j++) begin
            if (takeByte[j]) rdAcc[8*(LANES-1-j) +: 8] <= gathered[8*(LANES-1-j) +: 8];
          end
        end
      end
    end
  end

  assign writeReg = writeR;
  assign busAddr  = beatAddr;
  assign rspRdata = rdAcc;

  // R4
  lanes_in_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pbLogR == 2'd0) |-> (busBe[2:0] == 3'b000));

  // R4
  lanes_in_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pbLogR == 2'd1) |-> (busBe[1:0] == 2'b00));

  // R4
  idle_lanes_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busBe[3] == 1'b0) |-> (busWdata[31:24] == 8'h00));
endmodule

// File: rtl/busLaneSteer.sv
module busLaneSteer
  import lane_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [31:0]       reqWdata,
  input  logic [1:0]        portSel,
  input  logic              reqInternal,
  output logic              busValid,
  input  logic              busAck,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic [3:0]        busBe,
  output logic [31:0]       busWdata,
  input  logic [31:0]       busRdata,
  output logic              alignErr,
  output logic              rspDone,
  output logic [31:0]       rspRdata
);
  laneStrobe_t strobe;
  logic        misaligned;
  logic        lastBeat;
  logic        writeReg;

  laneCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .misaligned(misaligned),
    .busAck    (busAck),
    .lastBeat  (lastBeat),
    .writeReg  (writeReg),
    .strobe    (strobe),
    .busValid  (busValid),
    .reqReady  (reqReady),
    .alignErr  (alignErr),
    .rspDone   (rspDone)
  );

  laneDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqWrite   (reqWrite),
    .reqWdata   (reqWdata),
    .portSel    (portSel),
    .reqInternal(reqInternal),
    .busRdata   (busRdata),
    .misaligned (misaligned),
    .lastBeat   (lastBeat),
    .writeReg   (writeReg),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busBe      (busBe),
    .rspRdata   (rspRdata)
  );

  assign busWrite = writeReg;

  // R8
  beat_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busAck |=> $stable(busAddr) && $stable(busBe) && $stable(busWdata));

  // R4
  beat_has_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busBe != 4'b0000));
endmodule

// File: tb/busLaneSteer_tb.sv
module busLaneSteer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic [1:0]  portSel = '0;
  logic        reqInternal = 1'b0;
  logic        busValid;
  logic        busAck = 1'b0;
  logic [31:0] busAddr;
  logic        busWrite;
  logic [3:0]  busBe;
  logic [31:0] busWdata;
  logic [31:0] busRdata = '0;
  logic        alignErr;
  logic        rspDone;
  logic [31:0] rspRdata;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] mem [0:255];

  always #10 clk = ~clk;

  busLaneSteer #(.ADDR_W(32)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .portSel(portSel), .reqInternal(reqInternal), .busValid(busValid), .busAck(busAck),
    .busAddr(busAddr), .busWrite(busWrite), .busBe(busBe), .busWdata(busWdata),
    .busRdata(busRdata), .alignErr(alignErr), .rspDone(rspDone), .rspRdata(rspRdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runTxn(input logic [1:0] off, input logic [1:0] size, input logic [1:0] sel,
                        input logic intern, input logic wr, input int n);
    int szl, pbl, sz, pb, nb, beats, k, guard;
    bit mis, useWait, waited;
    logic [31:0] addr, wdata, expRd, expAddr;
    logic [7:0] oldB [4];
    logic [7:0] baseIdx;
    logic [3:0] expBe;
    szl = (size == 2'd3) ? 2 : int'(size);
    pbl = (!intern || sel == 2'd0 || sel == 2'd3) ? 2 : (sel == 2'd1 ? 1 : 0);
    sz = 1 << szl;
    pb = 1 << pbl;
    nb = (sz < pb) ? sz : pb;
    beats = sz / nb;
    addr = 32'h1000 + n * 4 + {30'd0, off};
    wdata = 32'h1357_9BDF ^ (n * 32'h0101_0107);
    mis = (szl == 1 && off[0]) || (szl == 2 && off != 2'd0);
    useWait = n[0];
    baseIdx = addr[7:0] & 8'hFC;
    for (int o = 0; o < 4; o++) oldB[o] = mem[baseIdx + 8'(o)];
    expRd = '0;
    for (int o = int'(off); o < int'(off) + sz; o++) expRd[31-8*o -: 8] = oldB[o];

    @(negedge clk);
    check(reqReady == 1'b1, "R9 ready before request", {31'd0, reqReady}, 32'd1);
    reqValid = 1'b1; reqAddr = addr; reqSize = size; reqWrite = wr;
    reqWdata = wdata; portSel = sel; reqInternal = intern;
    @(negedge clk);
    reqValid = 1'b0;
    if (mis) begin
      check(alignErr && !busValid, "R1 misaligned flagged, no beat", {30'd0, alignErr, busValid}, 32'd2);
      @(negedge clk);
      check(!alignErr && !busValid && !rspDone, "R1 flag lasts one cycle",
            {29'd0, alignErr, busValid, rspDone}, 32'd0);
      return;
    end
    check(!alignErr, "R1 aligned request not flagged", {31'd0, alignErr}, 32'd0);
    k = 0; waited = 0; guard = 0;
    forever begin
      if (rspDone) break;
      if (guard > 40) begin
        check(1'b0, "R7 transfer completes (watchdog)", 32'(k), 32'(beats));
        busAck = 1'b0;
        return;
      end
      guard++;
      if (busValid) begin
        check(!reqReady, "R8 not ready while busy", {31'd0, reqReady}, 32'd0);
        expAddr = (beats > 1) ? addr + 32'(k * pb) : addr;
        expBe = '0;
        for (int l = int'(expAddr[1:0]) % pb; l < int'(expAddr[1:0]) % pb + nb; l++) expBe[3-l] = 1'b1;
        if (useWait && !waited) begin
          busAck = 1'b0;
          waited = 1;
          check(busAddr == expAddr, "R8 address during wait", busAddr, expAddr);
        end else begin
          check(busAddr == expAddr, "R3 beat address", busAddr, expAddr);
          check(busBe == expBe, "R4 lane enables", {28'd0, busBe}, {28'd0, expBe});
          check(busWrite == wr, "R2 beat direction", {31'd0, busWrite}, {31'd0, wr});
          busAck = 1'b1;
          for (int l = 0; l < 4; l++) begin
            logic [7:0] mi;
            mi = (busAddr[7:0] & ~8'(pb - 1)) + 8'(l);
            busRdata[31-8*l -: 8] = (l < pb) ? mem[mi] : 8'hEE;
            if (wr && busBe[3-l]) mem[mi] = busWdata[31-8*l -: 8];
          end
          k++;
          waited = 0;
        end
      end else begin
        busAck = 1'b0;
      end
      @(negedge clk);
      busAck = 1'b0;
    end
    check(k == beats, "R3 beat count", 32'(k), 32'(beats));
    check(!busValid, "R7 bus idle at done", {31'd0, busValid}, 32'd0);
    if (!wr) begin
      check(rspRdata == expRd, "R6 gathered operand", rspRdata, expRd);
    end else begin
      logic [31:0] got, want;
      for (int o = 0; o < 4; o++) begin
        got[31-8*o -: 8] = mem[baseIdx + 8'(o)];
        want[31-8*o -: 8] = (o >= int'(off) && o < int'(off) + sz) ? wdata[31-8*o -: 8] : oldB[o];
      end
      check(got == want, "R5 stored bytes", got, want);
    end
    @(negedge clk);
    check(!rspDone, "R7 done lasts one cycle", {31'd0, rspDone}, 32'd0);
  endtask

  initial begin
    int n;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    check(!busValid && !alignErr && !rspDone && reqReady, "R9 reset state",
          {28'd0, busValid, alignErr, rspDone, reqReady}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check(!busValid && reqReady, "R9 after reset release", {30'd0, busValid, reqReady}, 32'd1);
    n = 0;
    for (int wr = 0; wr < 2; wr++)
      for (int intern = 0; intern < 2; intern++)
        for (int sel = 0; sel < 4; sel++)
          for (int size = 0; size < 4; size++)
            for (int off = 0; off < 4; off++) begin
              runTxn(2'(off), 2'(size), 2'(sel), 1'(intern), 1'(wr), n);
              n++;
            end
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(200000 * 20);
    testsRun++;
    testsFailed++;
    $display("FAIL R7 global watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule